// File: doc/BRIEF.md
# Windowed Sense Averaging and Fault Monitor

This block sits behind five 12-bit sense converters: two carry current readings and three carry voltage readings. Each sample arrives with a valid strobe. For every channel the block keeps two running averages on two free-running timebases that are not aligned with each other.

The short window produces an average that is compared with a per-channel limit. When the average is above the limit, a fault flag is set and stays set. The long window produces the mean of every sample accepted during that window and places it in a monitoring register. A channel index selects one of these registers for reading.

Alongside the averaged fault path, a fast comparator input cuts off the pulse-width-modulated drive for the rest of the current switching cycle. Drive comes back at the next cycle start.

Every sample input is a valid/ready stream. The block never applies back-pressure: each channel's ready is held high out of reset, and a sample counts in the cycle its valid is high. Control and status pins are plain levels or strobes. Reset is synchronous and active high.

Top module: `sense_avg_monitor`

## Requirements
- R1: While reset is high and right after it, every monitoring register reads 0, every fault flag is 0, and the drive output follows the drive input as long as the comparator is low.
- R2: Window 0 of the long timebase covers the first TELE_WIN rising edges after reset is released, and each later window abuts the one before. After a window ends, the register of channel c reads floor(sum/count) over the samples accepted on that channel in that window. This value is in place at most 40 cycles after the window's last edge and holds until the next update.
- R3: If a channel accepts no sample during a long window, its monitoring register keeps its previous value.
- R4: The read select picks channel 0..4 in the order primary current, secondary current, voltage 1, voltage 2, voltage 3. Select values 5 to 7 read 0. The read data changes only when the select changes or a register update occurs, and an update replaces all 12 bits at once.
- R5: The limit bus packs the limit of channel c into bits [12c+11:12c]. At the end of each FAULT_WIN-cycle short window, a channel with at least one sample sets its fault flag (bit c) when its short-window average is strictly greater than its limit. An average equal to the limit sets nothing.
- R6: A fault flag is set only from a short-window average, never from a single sample. One sample above the limit does not set the flag while the window average is at or below the limit.
- R7: A fault flag stays set until its clear bit is high. If a clear and a new fault decision fall in the same cycle, the flag ends up set.
- R8: While the fast comparator is high, the drive output is low. After the comparator has been high, the drive stays low until a cycle-start strobe arrives. If the comparator is high in the cycle-start cycle, that new cycle is cut off too.
- R9: Every channel's ready output is high in every cycle after reset, so no sample is ever refused.
- R10: The accumulators hold a full window of full-scale samples without overflow. A window in which every sample is 4095 reads back 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | 60 | Sample of channel c in bits [12c+11:12c] |
| smp_valid | input | 5 | Per-channel sample valid |
| smp_ready | output | 5 | Per-channel ready, always high out of reset |
| flt_limit | input | 60 | Fault limit of channel c in bits [12c+11:12c] |
| flt_clr | input | 5 | Per-channel fault clear |
| flt_flag | output | 5 | Sticky per-channel fault flags |
| rd_sel | input | 3 | Monitoring register select |
| rd_data | output | 12 | Selected monitoring register |
| pwm_in | input | 1 | Raw drive from the modulator |
| cyc_start | input | 1 | Switching-cycle start strobe |
| fast_cmp | input | 1 | Fast overcurrent comparator output |
| pwm_out | output | 1 | Drive after truncation |

## Verification
Two events can fall on the same edge: a fault decision that sets a flag and the clear of that flag. The bench holds the clear high through several short windows whose average is above the limit. It then counts the cycles in which the flag is seen high: each decision must show up as a one-cycle pulse rather than being swallowed. The same kind of collision on the drive path is provoked by raising the comparator in the cycle of a cycle-start strobe. The bench then checks that the new cycle stays cut off until the following start.

// File: rtl/sam_pkg.sv
package sam_pkg;
  localparam int NCH   = 5;
  localparam int SMP_W = 12;
  localparam int SEL_W = $clog2(NCH);
endpackage

// File: rtl/sam_tick.sv
// Free-running window timebase: bnd marks the last cycle of each window.
module sam_tick #(
  parameter int WIN = 50
) (
  input  logic clk,
  input  logic rst,
  output logic bnd
);
  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;

  logic [CW-1:0] cnt_q;

  assign bnd = (cnt_q == CW'(WIN - 1));

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (bnd) cnt_q <= '0;
    else          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sam_div.sv
// Restoring divider, one quotient bit per cycle; QW low bits of quotient kept.
module sam_div #(
  parameter int NW = 20,
  parameter int DW = 8,
  parameter int QW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [QW-1:0] quo
);
  localparam int KW = $clog2(NW + 1);

  logic [NW-1:0] n_q;
  logic [DW-1:0] d_q;
  logic [DW-1:0] r_q;
  logic [DW:0]   r_sh;
  logic [DW-1:0] r_nx;
  logic [QW-1:0] q_q;
  logic [KW-1:0] k_q;
  logic          busy_q;
  logic          ge;

  always_comb begin
    r_sh = {r_q, n_q[NW-1]};
    ge   = (r_sh >= {1'b0, d_q});
    r_nx = ge ? DW'(r_sh - {1'b0, d_q}) : r_sh[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q    <= '0;
      d_q    <= '0;
      r_q    <= '0;
      q_q    <= '0;
      k_q    <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        n_q    <= num;
        d_q    <= den;
        r_q    <= '0;
        k_q    <= KW'(NW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        n_q <= {n_q[NW-2:0], 1'b0};
        r_q <= r_nx;
        q_q <= {q_q[QW-2:0], ge};
        k_q <= k_q - 1'b1;
        if (k_q == KW'(1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign quo = q_q;
endmodule

// File: rtl/sam_win_acc.sv
// One channel, one window: accumulate, capture at boundary, divide.
module sam_win_acc #(
  parameter int SMP_W = 12,
  parameter int WIN   = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bnd,
  input  logic [SMP_W-1:0] smp,
  input  logic             vld,
  output logic             done,
  output logic [SMP_W-1:0] mean
);
  localparam int CNT_W = $clog2(WIN + 1);
  localparam int ACC_W = SMP_W + CNT_W;

  logic [ACC_W-1:0] sum_q, sum_nx, cap_sum_q;
  logic [CNT_W-1:0] num_q, num_nx, cap_num_q;
  logic             go_q;

  always_comb begin
    sum_nx = sum_q + (vld ? ACC_W'(smp) : '0);
    num_nx = num_q + CNT_W'(vld);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q     <= '0;
      num_q     <= '0;
      cap_sum_q <= '0;
      cap_num_q <= '0;
      go_q      <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (bnd) begin
        cap_sum_q <= sum_nx;
        cap_num_q <= num_nx;
        go_q      <= (num_nx != '0);
        sum_q     <= '0;
        num_q     <= '0;
      end else begin
        sum_q <= sum_nx;
        num_q <= num_nx;
      end
    end
  end

  sam_div #(
    .NW(ACC_W),
    .DW(CNT_W),
    .QW(SMP_W)
  ) u_div (
    .clk  (clk),
    .rst  (rst),
    .start(go_q),
    .num  (cap_sum_q),
    .den  (cap_num_q),
    .done (done),
    .quo  (mean)
  );
endmodule

// File: rtl/sam_pwm_cut.sv
// Cycle-by-cycle drive truncation on the fast comparator.
module sam_pwm_cut (
  input  logic clk,
  input  logic rst,
  input  logic pwm_in,
  input  logic cyc_start,
  input  logic fast_cmp,
  output logic pwm_out
);
  logic cut_q;
  logic cut_live;

  assign cut_live = fast_cmp | (cut_q & ~cyc_start);
  assign pwm_out  = pwm_in & ~cut_live;

  always_ff @(posedge clk) begin
    if (rst) cut_q <= 1'b0;
    else     cut_q <= cut_live;
  end
endmodule

// File: rtl/sense_avg_monitor.sv
module sense_avg_monitor
  import sam_pkg::*;
#(
  parameter int FAULT_WIN = 50,
  parameter int TELE_WIN  = 160
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCH*SMP_W-1:0]   smp_data,
  input  logic [NCH-1:0]         smp_valid,
  output logic [NCH-1:0]         smp_ready,
  input  logic [NCH*SMP_W-1:0]   flt_limit,
  input  logic [NCH-1:0]         flt_clr,
  output logic [NCH-1:0]         flt_flag,
  input  logic [SEL_W-1:0]       rd_sel,
  output logic [SMP_W-1:0]       rd_data,
  input  logic                   pwm_in,
  input  logic                   cyc_start,
  input  logic                   fast_cmp,
  output logic                   pwm_out
);
  logic             fbnd, tbnd;
  logic [NCH-1:0]   flt_done, tele_upd;
  logic [SMP_W-1:0] flt_mean  [NCH];
  logic [SMP_W-1:0] tele_mean [NCH];
  logic [SMP_W-1:0] tele_q    [NCH];

  assign smp_ready = {NCH{~rst}};

  sam_tick #(.WIN(FAULT_WIN)) u_ftick (.clk(clk), .rst(rst), .bnd(fbnd));
  sam_tick #(.WIN(TELE_WIN))  u_ttick (.clk(clk), .rst(rst), .bnd(tbnd));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    sam_win_acc #(.SMP_W(SMP_W), .WIN(FAULT_WIN)) u_fast (
      .clk (clk),
      .rst (rst),
      .bnd (fbnd),
      .smp (smp_data[g*SMP_W +: SMP_W]),
      .vld (smp_valid[g]),
      .done(flt_done[g]),
      .mean(flt_mean[g])
    );
    sam_win_acc #(.SMP_W(SMP_W), .WIN(TELE_WIN)) u_slow (
      .clk (clk),
      .rst (rst),
      .bnd (tbnd),
      .smp (smp_data[g*SMP_W +: SMP_W]),
      .vld (smp_valid[g]),
      .done(tele_upd[g]),
      .mean(tele_mean[g])
    );
  end

  // Sticky fault flags: a new decision wins over a clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      flt_flag <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (flt_done[c] && (flt_mean[c] > flt_limit[c*SMP_W +: SMP_W]))
          flt_flag[c] <= 1'b1;
        else if (flt_clr[c])
          flt_flag[c] <= 1'b0;
      end
    end
  end

  // Monitoring registers: whole-word replacement on update.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) tele_q[c] <= '0;
    end else begin
      for (int c = 0; c < NCH; c++)
        if (tele_upd[c]) tele_q[c] <= tele_mean[c];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCH; c++)
      if (rd_sel == SEL_W'(c)) rd_data = tele_q[c];
  end

  sam_pwm_cut u_cut (
    .clk      (clk),
    .rst      (rst),
    .pwm_in   (pwm_in),
    .cyc_start(cyc_start),
    .fast_cmp (fast_cmp),
    .pwm_out  (pwm_out)
  );
endmodule

// File: rtl/sam_checker.sv
module sam_checker
  import sam_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             fast_cmp,
  input logic             cyc_start,
  input logic             pwm_out,
  input logic [NCH-1:0]   flt_flag,
  input logic [NCH-1:0]   flt_clr,
  input logic [NCH-1:0]   flt_done,
  input logic [NCH-1:0]   tele_upd,
  input logic [SEL_W-1:0] rd_sel,
  input logic [SMP_W-1:0] rd_data
);
  AST_CMP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    fast_cmp |-> !pwm_out); // R8

  AST_CUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fast_cmp) && !cyc_start) |-> !pwm_out); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((($past(flt_flag) & ~$past(flt_clr)) & ~flt_flag) == '0)); // R7

  AST_FLAG_FROM_AVG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((flt_flag & ~$past(flt_flag) & ~$past(flt_done)) == '0)); // R6

  AST_READ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(rd_sel) && ($past(tele_upd) == '0)) |-> $stable(rd_data)); // R4
endmodule

bind sense_avg_monitor sam_checker u_chk (.*);

// File: tb/sim_sense_avg_monitor.sv
module sim_sense_avg_monitor;
  localparam int FW = 50;
  localparam int TW = 160;

  logic        clk = 1'b0;
  logic        rst;
  logic [59:0] smp_data;
  logic [4:0]  smp_valid;
  logic [4:0]  smp_ready;
  logic [59:0] flt_limit;
  logic [4:0]  flt_clr;
  logic [4:0]  flt_flag;
  logic [2:0]  rd_sel;
  logic [11:0] rd_data;
  logic        pwm_in, cyc_start, fast_cmp, pwm_out;

  always #4 clk = ~clk;

  sense_avg_monitor #(.FAULT_WIN(FW), .TELE_WIN(TW)) u0 (
    .clk(clk), .rst(rst), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .flt_limit(flt_limit), .flt_clr(flt_clr),
    .flt_flag(flt_flag), .rd_sel(rd_sel), .rd_data(rd_data),
    .pwm_in(pwm_in), .cyc_start(cyc_start), .fast_cmp(fast_cmp), .pwm_out(pwm_out)
  );

  typedef struct {
    logic [4:0][11:0] exp;
    logic [4:0]       emp;
    logic [4:0]       mx;
    int               due;
  } item_t;

  item_t q[$];
  int    nchk = 0, nfail = 0, ecnt = 0, mode = 0;
  bit    stop = 0, ended = 0;

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  function automatic bit gen_v(int m, int e, int ch);
    if (m == 1) return (e % 3) == (ch % 3);
    if (m == 2) return ch != 2;
    return 1'b1;
  endfunction

  function automatic int gen_d(int m, int e, int ch);
    case (m)
      0: return 100 * (ch + 1) + e % 7;
      1: return (e * 13 + ch * 301) % 4096;
      2: return 4095;
      3: return 1000;
      default: return ((e % FW) == 10) ? 4095 : 10;
    endcase
  endfunction

  always @(posedge clk) if (!rst) ecnt <= ecnt + 1;

  // Driver: applies samples and pushes the expected register set per long window.
  int          tsum [5];
  int          tcnt [5];
  bit          tmax [5];
  logic [11:0] prev [5];
  initial begin
    for (int c = 0; c < 5; c++) begin
      tsum[c] = 0; tcnt[c] = 0; tmax[c] = 1; prev[c] = '0;
    end
  end

  always @(negedge clk) begin
    item_t it;
    int    e, d;
    bit    v;
    if (rst) begin
      smp_valid = '0;
      smp_data  = '0;
    end else begin
      e = ecnt;
      for (int c = 0; c < 5; c++) begin
        v = gen_v(mode, e, c);
        d = gen_d(mode, e, c);
        smp_valid[c] = v;
        smp_data[c*12 +: 12] = d[11:0];
        if (v) begin
          tsum[c] += d;
          tcnt[c] += 1;
          if (d != 4095) tmax[c] = 0;
        end
      end
      if ((e % TW) == TW - 1) begin
        for (int c = 0; c < 5; c++) begin
          if (tcnt[c] > 0) prev[c] = 12'(tsum[c] / tcnt[c]);
          it.exp[c] = prev[c];
          it.emp[c] = (tcnt[c] == 0);
          it.mx[c]  = (tcnt[c] > 0) && tmax[c];
          tsum[c] = 0; tcnt[c] = 0; tmax[c] = 1;
        end
        it.due = e + 40;
        if (!stop) q.push_back(it);
      end
    end
  end

  // Monitor: pops expected register sets and reads them back at the due cycle.
  initial begin
    item_t it;
    rd_sel = '0;
    repeat (3) @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      rd_sel = 3'(s);
      #1 chk("R1 reset register", int'(rd_data), 0);
    end
    forever begin
      while (q.size() == 0) @(negedge clk);
      it = q.pop_front();
      while (ecnt <= it.due) @(negedge clk);
      for (int c = 0; c < 5; c++) begin
        rd_sel = 3'(c);
        #1;
        if (it.emp[c])     chk("R3 empty window holds", int'(rd_data), int'(it.exp[c]));
        else if (it.mx[c]) chk("R10 full scale mean", int'(rd_data), int'(it.exp[c]));
        else               chk("R2 window mean", int'(rd_data), int'(it.exp[c]));
      end
      for (int s = 5; s < 8; s++) begin
        rd_sel = 3'(s);
        #1 chk("R4 unused select", int'(rd_data), 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  task automatic set_mode(int m);
    @(posedge clk);
    mode = m;
  endtask

  task automatic pwm_step(bit pin, bit cs, bit fc, int exp, string req);
    @(negedge clk);
    pwm_in = pin; cyc_start = cs; fast_cmp = fc;
    #1 chk(req, int'(pwm_out), exp);
  endtask

  initial begin
    int hi0, hi1;
    rst = 1'b1; pwm_in = 1'b1; cyc_start = 1'b0; fast_cmp = 1'b0;
    flt_clr = '0; flt_limit = {5{12'd4095}};
    repeat (4) @(negedge clk);
    #1;
    chk("R1 reset flags", int'(flt_flag), 0);
    chk("R1 drive follows input", int'(pwm_out), 1);
    @(negedge clk) rst = 1'b0;
    #1 chk("R9 ready high", int'(smp_ready), 31);

    repeat (3 * TW) @(posedge clk);
    set_mode(1);
    repeat (3 * TW) @(posedge clk);
    chk("R9 ready high", int'(smp_ready), 31);
    set_mode(2);
    repeat (3 * TW) @(posedge clk);
    @(negedge clk) #1 chk("R5 average equal to limit", int'(flt_flag), 0);

    // Short-window fault decisions
    set_mode(3);
    flt_limit = {12'd4095, 12'd500, 12'd2000, 12'd1000, 12'd999};
    repeat (FW + 40) @(posedge clk);
    @(negedge clk) flt_clr = '1;
    @(negedge clk) flt_clr = '0;
    repeat (2 * FW + 40) @(posedge clk);
    @(negedge clk) #1 chk("R5 limit compare", int'(flt_flag), 5'b01001);

    set_mode(4);
    repeat (2 * FW + 40) @(posedge clk);
    @(negedge clk) #1 chk("R7 sticky without clear", int'(flt_flag), 5'b01001);
    @(negedge clk) flt_clr = '1;
    @(negedge clk) flt_clr = '0;
    #1 chk("R7 clear", int'(flt_flag), 0);
    repeat (2 * FW + 40) @(posedge clk);
    @(negedge clk) #1 chk("R6 single sample spike", int'(flt_flag), 0);

    // Clear held through fault decisions: each decision must still show.
    set_mode(3);
    @(negedge clk) flt_clr = '1;
    hi0 = 0; hi1 = 0;
    repeat (4 * FW) begin
      @(negedge clk);
      #1;
      if (flt_flag[0]) hi0++;
      if (flt_flag[1]) hi1++;
    end
    flt_clr = '0;
    chk("R7 set beats clear", int'(hi0 >= 2), 1);
    chk("R5 equal limit never sets", hi1, 0);

    // Drive truncation
    pwm_step(1, 0, 0, 1, "R8 drive passes");
    pwm_step(1, 0, 1, 0, "R8 comparator cuts");
    pwm_step(1, 0, 0, 0, "R8 cut held");
    pwm_step(1, 0, 0, 0, "R8 cut held");
    pwm_step(1, 1, 0, 1, "R8 resume at cycle start");
    pwm_step(1, 0, 0, 1, "R8 drive passes");
    pwm_step(1, 1, 1, 0, "R8 cut on cycle start");
    pwm_step(1, 0, 0, 0, "R8 new cycle stays cut");
    pwm_step(1, 1, 0, 1, "R8 resume at cycle start");
    pwm_step(0, 0, 0, 0, "R8 input low");

    stop = 1;
    while (q.size() != 0) @(negedge clk);
    repeat (60) @(posedge clk);
    finish_run();
  end
endmodule